// File: doc/BRIEF.md
# Receive Overflow Loss Counter Bank

This block keeps two 36-bit event tallies for a receive datapath. One tallies frames cut short because a receive FIFO stayed in overflow. The other tallies frames discarded outright for the same cause. Each event source raises a one-cycle pulse, and the matching tally advances by one.

Software reads each tally over a 32-bit, word-addressed, read-only port. A tally spans two adjacent word offsets. The lower word holds bits 31:0. The upper word holds bits 35:32 in its low nibble, and its remaining bits read as zero. Reading the upper word empties the tally, so a full read is lower word first, then upper word. A lower-word read on its own leaves the tally untouched, so software can poll it freely.

Read data is captured in a register one clock after the read strobe. Any clear happens on that same clock edge. Widths, the base offset and the number of tallies are parameters. The upper word holds the `CNT_W-DATA_W` bits above the bus width, so `CNT_W` must exceed `DATA_W` and be less than twice its value.

Top module: `rx_ovf_counter_bank`

## Requirements
- R1: After a synchronous active-low reset, both tallies are zero and `rd_data` is zero.
- R2: Each cycle with `evt_pulse[0]` high adds one to the truncated-frame tally, and each cycle with `evt_pulse[1]` high adds one to the dropped-frame tally. The two sources are independent.
- R3: The truncated tally is read at word 0x0C0 (bits 31:0) and 0x0C1 (bits 35:32 in bits 3:0). The dropped tally is read at 0x0C2 and 0x0C3 in the same layout. Bits 31:4 of an upper word are always zero.
- R4: A read of an upper word returns the tally's value before the clear and sets that tally to zero on the same edge.
- R5: A read of a lower word returns the tally's value and does not change the tally.
- R6: If an increment pulse coincides with a clearing read of the same tally, the read returns the old value and the tally becomes 1.
- R7: A read of any other offset returns zero and changes neither tally.
- R8: A tally at its all-ones value wraps to zero on the next increment and does not saturate.
- R9: `rd_data` changes only on the edge that samples `rd_en` high, one cycle after the strobe. It holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | N_CNT (2) | One-cycle event pulses: bit 0 = truncated frame, bit 1 = dropped frame |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W (12) | Word offset of the read |
| rd_data | output | DATA_W (32) | Registered read data |

## Verification
An increment pulse and a clearing upper-word read can hit the same tally in the same cycle. This collision is the case most likely to lose an event. The bench forces it on purpose for each tally, and it also lets it happen at random in a long mixed run of pulses and reads. A behavioural model judges every cycle: it returns the old value for the read and leaves a tally of 1. A follow-up lower-word read then brings that 1 out to the port. A second, narrow instance reaches the all-ones state within a few dozen pulses, so that wrap to zero is also judged against the model.

// File: rtl/ovf_cnt_pkg.sv
// Package: types shared by the overflow-loss counter bank.
// Assumes: nothing beyond IEEE 1800-2017.
package ovf_cnt_pkg;

    // Which half of a tally a read selects, if any.
    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_LOW  = 2'd1,
        WK_HIGH = 2'd2
    } word_kind_e;

endpackage

// File: rtl/ovf_addr_decode.sv
// Module: ovf_addr_decode
// Maps a read strobe and word offset onto a tally index and word half.
// Raises a clear request for the tally whose upper word is read.
// Assumes: tally k sits at BASE_WORD+2k (low) and BASE_WORD+2k+1 (high).
module ovf_addr_decode
    import ovf_cnt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned N_CNT     = 2,
    parameter int unsigned BASE_WORD = 'h0C0,
    localparam int unsigned IDX_W    = (N_CNT > 1) ? $clog2(N_CNT) : 1
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_kind_e        sel_kind,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [N_CNT-1:0]  clr_req
);

    // Purpose: compare the offset against every mapped word.
    always_comb begin
        sel_kind = WK_NONE;
        sel_idx  = '0;
        clr_req  = '0;
        for (int k = 0; k < N_CNT; k++) begin
            if (rd_en && rd_addr == ADDR_W'(BASE_WORD + 2 * k)) begin
                sel_kind = WK_LOW;
                sel_idx  = IDX_W'(k);
            end
            if (rd_en && rd_addr == ADDR_W'(BASE_WORD + 2 * k + 1)) begin
                sel_kind   = WK_HIGH;
                sel_idx    = IDX_W'(k);
                clr_req[k] = 1'b1;
            end
        end
    end

    // Guard: at most one tally is cleared by a single read (R4).
    always_comb begin
        assert_single_clear_R4: assert ($onehot0(clr_req));
    end

endmodule

// File: rtl/ovf_evt_counter.sv
// Module: ovf_evt_counter
// One wrapping tally. It counts single-cycle pulses and is cleared on request.
// A pulse that arrives with the clear is kept, so the result is 1.
// Assumes: inc is a clean one-cycle pulse per event.
module ovf_evt_counter #(
    parameter int unsigned CNT_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    // Purpose: clear with carry-in of a colliding pulse, else count and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= {{(CNT_W-1){1'b0}}, inc};
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !inc |=> cnt == '0);

    assert_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr && inc |=> cnt == CNT_W'(1));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && inc |=> cnt == CNT_W'($past(cnt) + 1'b1));

    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && inc && (&cnt) |=> cnt == '0);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !inc |=> $stable(cnt));

endmodule

// File: rtl/ovf_rd_mux.sv
// Module: ovf_rd_mux
// Registered read-data selection over all tallies.
// The upper word is zero-extended. Unmapped reads return zero.
// Assumes: CNT_W > DATA_W and CNT_W - DATA_W < DATA_W.
module ovf_rd_mux
    import ovf_cnt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 36,
    parameter int unsigned N_CNT  = 2,
    localparam int unsigned IDX_W = (N_CNT > 1) ? $clog2(N_CNT) : 1,
    localparam int unsigned HI_W  = CNT_W - DATA_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  word_kind_e                  sel_kind,
    input  logic [IDX_W-1:0]            sel_idx,
    input  logic [N_CNT-1:0][CNT_W-1:0] cnts,
    output logic [DATA_W-1:0]           rd_data
);

    // Purpose: capture the selected word on a strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (sel_kind)
                WK_LOW:  rd_data <= cnts[sel_idx][DATA_W-1:0];
                WK_HIGH: rd_data <= DATA_W'(cnts[sel_idx][CNT_W-1:DATA_W]);
                default: rd_data <= '0;
            endcase
        end
    end

    assert_upper_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && sel_kind == WK_HIGH |=> rd_data[DATA_W-1:HI_W] == '0);

    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && sel_kind == WK_NONE |=> rd_data == '0);

    assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/rx_ovf_counter_bank.sv
// Module: rx_ovf_counter_bank (top)
// A bank of wide overflow-loss tallies behind a 32-bit read-only word port.
// A tally is read as a lower word and then an upper word; reading the upper word clears it.
// Assumes: CNT_W > DATA_W, CNT_W - DATA_W < DATA_W, and the map fits in ADDR_W.
module rx_ovf_counter_bank
    import ovf_cnt_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CNT_W     = 36,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned N_CNT     = 2,
    parameter int unsigned BASE_WORD = 'h0C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CNT-1:0]  evt_pulse,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned IDX_W = (N_CNT > 1) ? $clog2(N_CNT) : 1;

    word_kind_e                  sel_kind;
    logic [IDX_W-1:0]            sel_idx;
    logic [N_CNT-1:0]            clr_req;
    logic [N_CNT-1:0][CNT_W-1:0] cnts;

    ovf_addr_decode #(
        .ADDR_W    (ADDR_W),
        .N_CNT     (N_CNT),
        .BASE_WORD (BASE_WORD)
    ) u_dec (
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .sel_kind (sel_kind),
        .sel_idx  (sel_idx),
        .clr_req  (clr_req)
    );

    // One tally per event source.
    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        ovf_evt_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (evt_pulse[g]),
            .clr   (clr_req[g]),
            .cnt   (cnts[g])
        );
    end

    ovf_rd_mux #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .N_CNT  (N_CNT)
    ) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel_kind (sel_kind),
        .sel_idx  (sel_idx),
        .cnts     (cnts),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/sim_rx_ovf_counter_bank.sv
`timescale 1ns/1ps
// Bench: two instances driven by the same stimulus.
// u0 uses the default widths. u1 is narrow (4-bit bus, 6-bit tally) so that wrap can be reached.
// A behavioural model predicts rd_data for every cycle.
module sim_rx_ovf_counter_bank;

    localparam int NDW = 4;
    localparam int NCW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  evt = '0;
    logic        ren = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] rd0;
    logic [3:0]  rd1;

    int tests = 0;
    int fails = 0;

    longint m0 [2];
    longint m1 [2];
    longint held0 = 0;
    longint held1 = 0;

    always #4 clk = ~clk;

    rx_ovf_counter_bank u0 (
        .clk (clk), .rst_n (rst_n), .evt_pulse (evt),
        .rd_en (ren), .rd_addr (addr), .rd_data (rd0)
    );

    rx_ovf_counter_bank #(.DATA_W(NDW), .CNT_W(NCW)) u1 (
        .clk (clk), .rst_n (rst_n), .evt_pulse (evt),
        .rd_en (ren), .rd_addr (addr), .rd_data (rd1)
    );

    function automatic longint lomask(int w);
        return (longint'(1) <<< w) - 1;
    endfunction

    // Word returned for an offset, given the tallies before the edge.
    function automatic longint word_of(longint c0, longint c1, logic [11:0] a, int dw);
        case (a)
            12'h0C0: return c0 & lomask(dw);
            12'h0C1: return c0 >>> dw;
            12'h0C2: return c1 & lomask(dw);
            12'h0C3: return c1 >>> dw;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle just after a falling edge, advance the model, compare at the next falling edge.
    task automatic step(logic [1:0] ev, logic en, logic [11:0] a, string tag);
        longint e0, e1;
        evt = ev; ren = en; addr = a;
        e0 = en ? word_of(m0[0], m0[1], a, 32) : held0;
        e1 = en ? word_of(m1[0], m1[1], a, NDW) : held1;
        for (int k = 0; k < 2; k++) begin
            if (en && a == 12'(12'h0C1 + 2 * k)) begin
                m0[k] = longint'(ev[k]);
                m1[k] = longint'(ev[k]);
            end else begin
                m0[k] = (m0[k] + longint'(ev[k])) & lomask(36);
                m1[k] = (m1[k] + longint'(ev[k])) & lomask(NCW);
            end
        end
        held0 = e0;
        held1 = e1;
        @(negedge clk);
        check(tag, longint'(rd0), e0);
        check(tag, longint'(rd1), e1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog R9: got timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [11:0] pick [6];
        pick[0] = 12'h0C0; pick[1] = 12'h0C1; pick[2] = 12'h0C2;
        pick[3] = 12'h0C3; pick[4] = 12'h0C4; pick[5] = 12'h0BF;
        m0[0] = 0; m0[1] = 0; m1[0] = 0; m1[1] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the port.
        check("R1", longint'(rd0), 0);
        check("R1", longint'(rd1), 0);
        step(2'b00, 1'b1, 12'h0C0, "R1");
        step(2'b00, 1'b1, 12'h0C1, "R1");
        step(2'b00, 1'b1, 12'h0C2, "R1");
        step(2'b00, 1'b1, 12'h0C3, "R1");

        // R2: independent counting, truncated=5, dropped=3.
        repeat (3) step(2'b11, 1'b0, 12'h0C0, "R9");
        repeat (2) step(2'b01, 1'b0, 12'h0C0, "R9");
        step(2'b00, 1'b1, 12'h0C0, "R2");
        step(2'b00, 1'b1, 12'h0C2, "R2");
        // R5: a repeated lower read leaves the tally.
        step(2'b00, 1'b1, 12'h0C0, "R5");
        step(2'b00, 1'b1, 12'h0C0, "R5");
        // R9: data holds with no strobe.
        repeat (3) step(2'b00, 1'b0, 12'h0C2, "R9");
        // R3/R4: upper read, then cleared.
        step(2'b00, 1'b1, 12'h0C1, "R3");
        step(2'b00, 1'b1, 12'h0C0, "R4");
        step(2'b00, 1'b1, 12'h0C2, "R4");

        // R6: a pulse colliding with the clearing read is kept.
        step(2'b01, 1'b1, 12'h0C1, "R6");
        step(2'b00, 1'b1, 12'h0C0, "R6");
        step(2'b10, 1'b1, 12'h0C3, "R6");
        step(2'b00, 1'b1, 12'h0C2, "R6");

        // R7: unmapped offsets read zero and leave the tallies.
        step(2'b00, 1'b1, 12'h0C4, "R7");
        step(2'b00, 1'b1, 12'h0BF, "R7");
        step(2'b00, 1'b1, 12'h0FF, "R7");
        step(2'b00, 1'b1, 12'h000, "R7");
        step(2'b00, 1'b1, 12'h0C0, "R7");
        step(2'b00, 1'b1, 12'h0C2, "R7");

        // R8: fill the narrow tally to all ones, read both halves, then wrap.
        step(2'b00, 1'b1, 12'h0C1, "R4");
        step(2'b00, 1'b1, 12'h0C3, "R4");
        repeat (63) step(2'b01, 1'b0, 12'h0C0, "R9");
        step(2'b00, 1'b1, 12'h0C0, "R3");
        step(2'b10, 1'b1, 12'h0C1, "R3");
        repeat (64) step(2'b01, 1'b0, 12'h0C0, "R9");
        step(2'b00, 1'b1, 12'h0C0, "R8");
        step(2'b00, 1'b1, 12'h0C1, "R8");

        // Mixed run: random pulses, reads and collisions against the model.
        for (int i = 0; i < 3000; i++) begin
            step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 pick[$urandom_range(0, 5)], "R2");
        end
        step(2'b00, 1'b1, 12'h0C1, "R4");
        step(2'b00, 1'b1, 12'h0C3, "R4");
        step(2'b00, 1'b1, 12'h0C0, "R4");

        evt = '0; ren = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule